// File: doc/BRIEF.md
# Frame Parity Error Tally

This block keeps per-frame tallies of parity mismatches for the section, line and path parity bytes of a SONET/SDH receiver. Once per frame the receive side offers, for each of the three channels, the parity byte carried in the signal and the parity byte it computed itself, together with a single valid strobe. The block compares each pair and adds the result to a running count. Depending on a mode input, the addition is either the number of mismatching bit positions or a single unit for any mismatch at all.

Each channel also keeps a latched count. A latch request copies the running count into the latched register and restarts the running count in the same clock edge, so a reader sees stable, non-overlapping intervals. The path channel is forced to zero, both running and latched, while the out-of-frame or path loss-of-pointer alarm is active, because its parity is meaningless in those states. Channel k uses byte k of the parity inputs and field k of the count outputs: channel 0 is the section parity (bits 7:0), channel 1 the line parity (bits 15:8) and channel 2 the path parity (bits 23:16).

Top module: `bip_err_tally`

## Requirements
- R1: After reset every running count and every latched count reads zero.
- R2: With `blk_mode` low (bit mode), a frame with `frame_vld` high adds to the channel's running count the number of set bits in the XOR of its received and computed parity bytes (0 to 8).
- R3: With `blk_mode` high (block mode), a frame with `frame_vld` high adds 1 when the received and computed bytes differ and 0 when they match.
- R4: With `frame_vld` low, parity inputs have no effect: running counts keep their value.
- R5: A `latch_req` pulse copies each channel's running count, as it was before that edge, into its latched count and restarts the running count.
- R6: A frame arriving in the same cycle as `latch_req` is not lost: the new running count equals that frame's contribution alone.
- R7: A running count saturates at 2^CNT_W-1 and never wraps to a smaller value.
- R8: While `oof_alarm` is high, channel 2's running and latched counts are zero.
- R9: While `lopp_alarm` is high, channel 2's running and latched counts are zero.
- R10: Channels 0 and 1 keep counting and keep their latched counts regardless of either alarm.
- R11: Latched counts keep their value between latch requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_vld | input | 1 | One-cycle strobe: parity bytes for a frame are valid |
| blk_mode | input | 1 | 0 = count errored bits, 1 = count errored blocks |
| latch_req | input | 1 | Copy running counts to latched counts and restart |
| oof_alarm | input | 1 | Out-of-frame alarm state |
| lopp_alarm | input | 1 | Path loss-of-pointer alarm state |
| rx_bip | input | NUM_CH*8 | Received parity bytes, channel k in byte k |
| calc_bip | input | NUM_CH*8 | Locally computed parity bytes, channel k in byte k |
| run_cnt | output | NUM_CH*CNT_W | Running counts, channel k in field k |
| lat_cnt | output | NUM_CH*CNT_W | Latched counts, channel k in field k |

## Verification
Every result of this block, running count, latched count and the alarm clearing alike, is due exactly one clock edge after the inputs that cause it are sampled, since each count sits in a single register behind the comparison logic. The bench therefore sets inputs on the falling edge, lets one rising edge pass, and compares both counts of all three channels with its own model at the next falling edge. The model updates on the same edge using a bit-by-bit loop for the mismatch weight, so every step checks the result of exactly the frame just applied.

// File: rtl/bip_tally_pkg.sv
package bip_tally_pkg;
  localparam int PAR_W = 8;
  localparam int WGT_W = $clog2(PAR_W + 1);

  // Contribution of one frame: mismatching bits, or one per errored block.
  function automatic logic [WGT_W-1:0] bip_weight(input logic [PAR_W-1:0] diff,
                                                  input logic blk);
    if (blk) return WGT_W'(|diff);
    return WGT_W'($countones(diff));
  endfunction
endpackage

// File: rtl/bip_err_weigh.sv
module bip_err_weigh
  import bip_tally_pkg::*;
(
  input  logic [PAR_W-1:0] rx_byte,
  input  logic [PAR_W-1:0] calc_byte,
  input  logic             blk_mode,
  output logic [WGT_W-1:0] weight,
  output logic             err_evt
);
  logic [PAR_W-1:0] diff;

  always_comb begin
    diff    = rx_byte ^ calc_byte;
    weight  = bip_weight(diff, blk_mode);
    err_evt = (weight != '0);
  end

  always_comb begin
    AST_WEIGHT_MAX: assert (weight <= WGT_W'(PAR_W)); // R2
    AST_BLOCK_UNIT: assert (!blk_mode || weight <= WGT_W'(1)); // R3
  end
endmodule

// File: rtl/bip_chan_tally.sv
module bip_chan_tally
  import bip_tally_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             latch_i,
  input  logic             vld_i,
  input  logic [WGT_W-1:0] weight_i,
  output logic [CNT_W-1:0] run_q,
  output logic [CNT_W-1:0] lat_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] base;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] run_nxt;
  logic             sat_evt;

  always_comb begin
    base    = latch_i ? '0 : run_q;
    sum     = {1'b0, base} + (vld_i ? (CNT_W+1)'(weight_i) : '0);
    sat_evt = sum[CNT_W];
    run_nxt = sat_evt ? CNT_MAX : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hold_i) begin
      run_q <= '0;
      lat_q <= '0;
    end else begin
      run_q <= run_nxt;
      if (latch_i) lat_q <= run_q;
    end
  end

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (run_q == '0 && lat_q == '0)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !latch_i) |=> (run_q >= $past(run_q))); // R7
  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && latch_i) |=> (lat_q == $past(run_q))); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !latch_i && !vld_i) |=> $stable(run_q)); // R4
  AST_LAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !latch_i) |=> $stable(lat_q)); // R11
endmodule

// File: rtl/bip_err_tally.sv
module bip_err_tally
  import bip_tally_pkg::*;
#(
  parameter int                 NUM_CH      = 3,
  parameter int                 CNT_W       = 16,
  parameter logic [NUM_CH-1:0]  HOLD_ON_OOF = 3'b100,
  parameter logic [NUM_CH-1:0]  HOLD_ON_LOP = 3'b100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_vld,
  input  logic                    blk_mode,
  input  logic                    latch_req,
  input  logic                    oof_alarm,
  input  logic                    lopp_alarm,
  input  logic [NUM_CH*PAR_W-1:0] rx_bip,
  input  logic [NUM_CH*PAR_W-1:0] calc_bip,
  output logic [NUM_CH*CNT_W-1:0] run_cnt,
  output logic [NUM_CH*CNT_W-1:0] lat_cnt
);
  logic [NUM_CH-1:0] hold_evt;
  logic [NUM_CH-1:0] err_evt;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [WGT_W-1:0] weight;

    assign hold_evt[ch] = (oof_alarm & HOLD_ON_OOF[ch]) | (lopp_alarm & HOLD_ON_LOP[ch]);

    bip_err_weigh u_weigh (
      .rx_byte  (rx_bip[ch*PAR_W +: PAR_W]),
      .calc_byte(calc_bip[ch*PAR_W +: PAR_W]),
      .blk_mode (blk_mode),
      .weight   (weight),
      .err_evt  (err_evt[ch])
    );

    bip_chan_tally #(.CNT_W(CNT_W)) u_tally (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold_i  (hold_evt[ch]),
      .latch_i (latch_req),
      .vld_i   (frame_vld),
      .weight_i(weight),
      .run_q   (run_cnt[ch*CNT_W +: CNT_W]),
      .lat_q   (lat_cnt[ch*CNT_W +: CNT_W])
    );

    if (!HOLD_ON_OOF[ch] && !HOLD_ON_LOP[ch]) begin : g_free
      AST_ALARM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_req && frame_vld && err_evt[ch]) |=>
          (run_cnt[ch*CNT_W +: CNT_W] != '0)); // R10
    end
  end
endmodule

// File: tb/bip_err_tally_tb.sv
module bip_err_tally_tb;
  localparam int NCH  = 3;
  localparam int CW   = 16;
  localparam int CMAX = (1 << CW) - 1;
  localparam int VW   = 5 + 48;
  localparam int NVEC = 12;

  // {blk_mode, vld, latch, oof, lop, rx[23:0], calc[23:0]}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {5'b01000, 24'h00_00_01, 24'h00_00_00},
    {5'b01000, 24'hFF_0F_00, 24'h00_00_00},
    {5'b01000, 24'hA5_5A_33, 24'hA5_5A_33},
    {5'b01000, 24'h81_7E_C3, 24'h00_00_00},
    {5'b00000, 24'hFF_FF_FF, 24'h00_00_00},
    {5'b01100, 24'h12_34_56, 24'h12_30_50},
    {5'b11000, 24'hFF_01_80, 24'h00_00_00},
    {5'b11000, 24'h3C_3C_3C, 24'h3C_3C_3C},
    {5'b11000, 24'h01_00_FF, 24'h00_00_FE},
    {5'b10000, 24'hFF_FF_FF, 24'h00_00_00},
    {5'b11100, 24'h10_20_40, 24'h00_00_00},
    {5'b01000, 24'hF0_0F_AA, 24'h0F_0F_55}
  };

  logic clk = 1'b0;
  logic rst_n, frame_vld, blk_mode, latch_req, oof_alarm, lopp_alarm;
  logic [NCH*8-1:0]  rx_bip, calc_bip;
  logic [NCH*CW-1:0] run_cnt, lat_cnt;

  int errors = 0;
  int checks = 0;
  int m_run [NCH];
  int m_lat [NCH];

  always #5 clk = ~clk;

  bip_err_tally u_dut (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .blk_mode(blk_mode),
    .latch_req(latch_req), .oof_alarm(oof_alarm), .lopp_alarm(lopp_alarm),
    .rx_bip(rx_bip), .calc_bip(calc_bip), .run_cnt(run_cnt), .lat_cnt(lat_cnt)
  );

  function automatic int tb_weight(input logic [7:0] a, input logic [7:0] b, input logic blk);
    int n = 0;
    for (int i = 0; i < 8; i++) if (a[i] != b[i]) n++;
    if (blk) return (n > 0) ? 1 : 0;
    return n;
  endfunction

  task automatic cmp(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int ch = 0; ch < NCH; ch++) begin
      cmp(int'(run_cnt[ch*CW +: CW]), m_run[ch], tag, $sformatf("run ch%0d", ch));
      cmp(int'(lat_cnt[ch*CW +: CW]), m_lat[ch], tag, $sformatf("lat ch%0d", ch));
    end
  endtask

  // Drive at falling edge, one rising edge, compare at next falling edge.
  task automatic step(input logic md, input logic v, input logic lt, input logic of,
                      input logic lp, input logic [23:0] rx, input logic [23:0] cb,
                      input string tag);
    blk_mode = md; frame_vld = v; latch_req = lt; oof_alarm = of; lopp_alarm = lp;
    rx_bip = rx; calc_bip = cb;
    @(posedge clk);
    for (int ch = 0; ch < NCH; ch++) begin
      int w = v ? tb_weight(rx[ch*8 +: 8], cb[ch*8 +: 8], md) : 0;
      if (ch == 2 && (of || lp)) begin
        m_run[ch] = 0; m_lat[ch] = 0;
      end else begin
        int base = m_run[ch];
        if (lt) begin m_lat[ch] = m_run[ch]; base = 0; end
        m_run[ch] = (base + w > CMAX) ? CMAX : base + w;
      end
    end
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_vld = 0; blk_mode = 0; latch_req = 0;
    oof_alarm = 0; lopp_alarm = 0; rx_bip = '0; calc_bip = '0;
    for (int ch = 0; ch < NCH; ch++) begin m_run[ch] = 0; m_lat[ch] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");

    // Table walk: bit mode (R2) and block mode (R3) rows
    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] r = VEC[i];
      step(r[52], r[51], r[50], r[49], r[48], r[47:24], r[23:0], r[52] ? "R3" : "R2");
    end

    // R4: strobe low, differing bytes ignored
    step(0, 0, 0, 0, 0, 24'hFF_FF_FF, 24'h00_00_00, "R4");
    step(1, 0, 0, 0, 0, 24'h0F_F0_11, 24'h00_00_00, "R4");

    // R5: latch without frame
    step(0, 1, 0, 0, 0, 24'h07_03_01, 24'h00_00_00, "R2");
    step(0, 0, 1, 0, 0, 24'h00_00_00, 24'h00_00_00, "R5");
    // R11: latched value kept
    step(0, 1, 0, 0, 0, 24'hFF_FF_FF, 24'h00_00_00, "R11");
    step(0, 0, 0, 0, 0, 24'h00_00_00, 24'h00_00_00, "R11");
    // R6: frame coincident with latch
    step(0, 1, 1, 0, 0, 24'h03_0F_3F, 24'h00_00_00, "R6");
    step(1, 1, 1, 0, 0, 24'h01_00_80, 24'h00_00_00, "R6");

    // R8 / R10: OOF clears channel 2 only
    step(0, 1, 0, 1, 0, 24'hFF_FF_FF, 24'h00_00_00, "R8");
    step(0, 1, 0, 1, 0, 24'h0F_0F_0F, 24'h00_00_00, "R10");
    step(0, 1, 1, 1, 0, 24'h01_01_01, 24'h00_00_00, "R10");
    step(0, 1, 0, 0, 0, 24'h03_03_03, 24'h00_00_00, "R8");
    step(0, 0, 1, 0, 0, 24'h00_00_00, 24'h00_00_00, "R5");
    // R9: LOP-P clears channel 2
    step(0, 1, 0, 0, 1, 24'hFF_FF_FF, 24'h00_00_00, "R9");
    step(1, 1, 0, 0, 1, 24'hFF_FF_FF, 24'h00_00_00, "R9");
    step(0, 1, 0, 0, 0, 24'h01_01_01, 24'h00_00_00, "R9");

    // R7: saturation
    for (int k = 0; k < 8200; k++)
      step(0, 1, 0, 0, 0, 24'hFF_FF_FF, 24'h00_00_00, "R7");
    cmp(int'(run_cnt[CW-1:0]), CMAX, "R7", "run ch0 at max");
    step(0, 1, 0, 0, 0, 24'h01_01_01, 24'h00_00_00, "R7");
    step(0, 1, 1, 0, 0, 24'h01_01_01, 24'h00_00_00, "R5");
    cmp(int'(lat_cnt[CW +: CW]), CMAX, "R5", "lat ch1 saturated copy");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule